// File: doc/BRIEF.md
# Skip-Four JK Sequence Counter

This block is a three-bit synchronous counter made of three JK storage cells. All three cells share one falling-edge clock. The state, read as C (most significant), B, A, repeats the pattern 000, 001, 010, 011, 101, so the value 100 never appears in normal counting. Each cell's next value comes from its own J and K excitation terms. No adder or incrementer is used. A parameterized divider turns the fast system clock into a one-cycle step enable, so in the target system the counter advances at a slow human-visible rate. The cells only update on a falling system-clock edge while that enable is high.

There are two ways to clear the counter. The first is an active-low clear input that acts on all three cells at once, with no clock needed. The second is a raw pushbutton, active high when pressed. The button passes through a two-flop synchronizer and then a debouncer, and the debounced level drives the same asynchronous clear path. A seed port loads any three-bit value on a falling edge. This lets the unused codes 100, 110 and 111 be forced, and the counter's return from them into the main loop be observed. Both the true outputs and the complemented outputs are brought out.

Named states: ST_ZERO (000), ST_ONE (001), ST_TWO (010), ST_THREE (011), ST_FIVE (101), and the unused ST_FOUR_X (100), ST_SIX_X (110), ST_SEVEN_X (111). Named transitions on each step: ST_ZERO to ST_ONE, ST_ONE to ST_TWO, ST_TWO to ST_THREE, ST_THREE to ST_FIVE (skip), ST_FIVE to ST_ZERO (wrap), ST_FOUR_X to ST_ONE, ST_SIX_X to ST_THREE, ST_SEVEN_X to ST_ONE (recoveries). Each cell applies one of four actions: JK_HOLD (J=0, K=0), JK_CLR (J=0, K=1), JK_SET (J=1, K=0) or JK_TGL (J=1, K=1).

Top module: `skip4_jk_counter`

## Requirements
- R1: On each step the state cnt_q (bit 2 = C, bit 1 = B, bit 0 = A) moves 000→001→010→011→101→000. The excitation terms are: C uses J=B·A and K=1; B uses J=¬C·A and K=A; A uses J=1 and K=¬B.
- R2: The state changes only on a falling system-clock edge where the step enable is high. On every other edge it holds.
- R3: The unused codes recover within one step: 100→001, 110→011, 111→001.
- R4: While clr_n is low, cnt_q is 000 and cnt_qn is 111 at once, with no clock edge needed. This clear overrides the step enable and the seed load.
- R5: cnt_qn is always the bitwise complement of cnt_q.
- R6: After clr_n is released, the step enable is high for one system cycle in every DIV_COUNT cycles.
- R7: If btn_raw is held high for longer than DEB_CYCLES plus two synchronizer cycles, the counter is cleared to 000 and stays there while the button is held.
- R8: A btn_raw pulse shorter than DEB_CYCLES cycles has no effect on the count.
- R9: If seed_en is high at a falling edge, cnt_q takes seed_val on that edge. The load takes priority over a step, and the clear takes priority over the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock; the cells update on its falling edge |
| clr_n | input | 1 | Active-low asynchronous clear; also resets the divider and debouncer |
| btn_raw | input | 1 | Raw reset pushbutton, high when pressed, asynchronous to clk_sys |
| seed_en | input | 1 | Load strobe for seed_val |
| seed_val | input | 3 | Value to load, bit 2 = C |
| cnt_q | output | 3 | Counter state C, B, A |
| cnt_qn | output | 3 | Complement of cnt_q |

## Verification
Two functions can fall in the same cycle. A step can coincide with the asynchronous clear, and a seed load can coincide with the clear. The bench's reference model tracks when the step enable is due. The bench drops clr_n just after the rising edge that raises the enable, and in one case also drives seed_en with a nonzero seed. It then checks that the outputs read 000/111 before the falling edge, and that they still read 000/111 after that edge, where a step or load would otherwise have landed.

// File: rtl/skip4_pkg.sv
package skip4_pkg;

    typedef enum logic [2:0] {
        ST_ZERO    = 3'b000,
        ST_ONE     = 3'b001,
        ST_TWO     = 3'b010,
        ST_THREE   = 3'b011,
        ST_FOUR_X  = 3'b100,
        ST_FIVE    = 3'b101,
        ST_SIX_X   = 3'b110,
        ST_SEVEN_X = 3'b111
    } cnt_state_e;

    typedef enum logic [1:0] {
        JK_HOLD = 2'b00,
        JK_CLR  = 2'b01,
        JK_SET  = 2'b10,
        JK_TGL  = 2'b11
    } jk_op_e;

    localparam int CNT_BITS = 3;

endpackage

// File: rtl/jk_cell.sv
module jk_cell
    import skip4_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic step_en,
    input  logic load_en,
    input  logic load_d,
    input  logic j,
    input  logic k,
    output logic q,
    output logic qn
);

    jk_op_e op;

    always_comb begin
        op = jk_op_e'({j, k});
    end

    always_ff @(negedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else if (load_en) begin
            q <= load_d;
        end else if (step_en) begin
            unique case (op)
                JK_HOLD: q <= q;
                JK_CLR:  q <= 1'b0;
                JK_SET:  q <= 1'b1;
                JK_TGL:  q <= ~q;
            endcase
        end
    end

    assign qn = ~q;

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int DIV_COUNT = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int DW = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV_COUNT - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/button_filter.sv
module button_filter #(
    parameter int DEB_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);

    localparam int CW = $clog2(DEB_CYCLES) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

    logic [1:0]    sync;
    logic [CW-1:0] stable_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync       <= '0;
            stable_cnt <= '0;
            clean      <= 1'b0;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] == clean) begin
                stable_cnt <= '0;
            end else if (stable_cnt == LIMIT) begin
                clean      <= sync[1];
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/skip4_jk_counter.sv
module skip4_jk_counter
    import skip4_pkg::*;
#(
    parameter int DIV_COUNT  = 50_000_000,
    parameter int DEB_CYCLES = 1_000_000
) (
    input  logic                clk_sys,
    input  logic                clr_n,
    input  logic                btn_raw,
    input  logic                seed_en,
    input  logic [CNT_BITS-1:0] seed_val,
    output logic [CNT_BITS-1:0] cnt_q,
    output logic [CNT_BITS-1:0] cnt_qn
);

    logic                btn_clean;
    logic                clr_all_n;
    logic                step_tick;
    logic [CNT_BITS-1:0] j_in;
    logic [CNT_BITS-1:0] k_in;

    tick_divider #(.DIV_COUNT(DIV_COUNT)) u_div (
        .clk   (clk_sys),
        .rst_n (clr_n),
        .tick  (step_tick)
    );

    button_filter #(.DEB_CYCLES(DEB_CYCLES)) u_btn (
        .clk   (clk_sys),
        .rst_n (clr_n),
        .raw   (btn_raw),
        .clean (btn_clean)
    );

    assign clr_all_n = clr_n & ~btn_clean;

    // Excitation terms: bit 2 = C, bit 1 = B, bit 0 = A (R1, R3)
    always_comb begin
        j_in[2] = cnt_q[1] & cnt_q[0];
        k_in[2] = 1'b1;
        j_in[1] = ~cnt_q[2] & cnt_q[0];
        k_in[1] = cnt_q[0];
        j_in[0] = 1'b1;
        k_in[0] = ~cnt_q[1];
    end

    for (genvar i = 0; i < CNT_BITS; i++) begin : g_cell
        jk_cell u_cell (
            .clk     (clk_sys),
            .clr_n   (clr_all_n),
            .step_en (step_tick),
            .load_en (seed_en),
            .load_d  (seed_val[i]),
            .j       (j_in[i]),
            .k       (k_in[i]),
            .q       (cnt_q[i]),
            .qn      (cnt_qn[i])
        );
    end

endmodule

module skip4_checker
    import skip4_pkg::*;
#(
    parameter int DIV_COUNT = 2
) (
    input logic                clk_sys,
    input logic                clr_n,
    input logic                clr_all_n,
    input logic                step_tick,
    input logic                seed_en,
    input logic [CNT_BITS-1:0] seed_val,
    input logic [CNT_BITS-1:0] cnt_q,
    input logic [CNT_BITS-1:0] cnt_qn
);

    function automatic logic [2:0] expect_next(input logic [2:0] s);
        case (s)
            3'b000:  return 3'b001;
            3'b001:  return 3'b010;
            3'b010:  return 3'b011;
            3'b011:  return 3'b101;
            3'b101:  return 3'b000;
            3'b110:  return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    assert_step_order_R1: assert property (@(negedge clk_sys) disable iff (!clr_all_n)
        (step_tick && !seed_en) |=> (cnt_q == expect_next($past(cnt_q))));

    assert_hold_no_step_R2: assert property (@(negedge clk_sys) disable iff (!clr_all_n)
        (!step_tick && !seed_en) |=> $stable(cnt_q));

    assert_seed_load_R9: assert property (@(negedge clk_sys) disable iff (!clr_all_n)
        seed_en |=> (cnt_q == $past(seed_val)));

    assert_clear_forces_zero_R4: assert property (@(posedge clk_sys)
        !clr_all_n |-> (cnt_q == 3'b000 && cnt_qn == 3'b111));

    assert_complement_R5: assert property (@(posedge clk_sys) disable iff (!clr_n)
        cnt_qn == ~cnt_q);

    assert_tick_single_R6: assert property (@(posedge clk_sys) disable iff (!clr_n)
        (DIV_COUNT > 1 && step_tick) |=> !step_tick);

endmodule

bind skip4_jk_counter skip4_checker #(.DIV_COUNT(DIV_COUNT)) u_chk (
    .clk_sys   (clk_sys),
    .clr_n     (clr_n),
    .clr_all_n (clr_all_n),
    .step_tick (step_tick),
    .seed_en   (seed_en),
    .seed_val  (seed_val),
    .cnt_q     (cnt_q),
    .cnt_qn    (cnt_qn)
);

// File: tb/tb_skip4_jk_counter.sv
`timescale 1ns/1ps
module tb_skip4_jk_counter;

    localparam int DIV = 4;
    localparam int DEB = 8;

    logic       clk_sys = 1'b0;
    logic       clr_n;
    logic       btn_raw;
    logic       seed_en;
    logic [2:0] seed_val;
    logic [2:0] cnt_q;
    logic [2:0] cnt_qn;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // reference model state
    int mstate = 0;
    int mcnt   = 0;
    bit mtick  = 0;
    bit cmp_en = 0;

    always #5 clk_sys = ~clk_sys;

    skip4_jk_counter #(.DIV_COUNT(DIV), .DEB_CYCLES(DEB)) dut (
        .clk_sys  (clk_sys),
        .clr_n    (clr_n),
        .btn_raw  (btn_raw),
        .seed_en  (seed_en),
        .seed_val (seed_val),
        .cnt_q    (cnt_q),
        .cnt_qn   (cnt_qn)
    );

    function automatic int seq_next(input int s);
        case (s)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 5;
            5: return 0;
            6: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model: compare every rising edge, then advance the step divider (R1, R2, R5, R6)
    always @(posedge clk_sys) begin
        cyc++;
        if (cmp_en) begin
            chk(int'(cnt_q) == mstate, "R1/R2/R6 state vs model", int'(cnt_q), mstate);
            chk(cnt_qn == ~cnt_q, "R5 complement", int'(cnt_qn), int'(~cnt_q));
        end
        if (!clr_n) begin
            mcnt = 0; mtick = 0;
        end else if (mcnt == DIV - 1) begin
            mcnt = 0; mtick = 1;
        end else begin
            mcnt = mcnt + 1; mtick = 0;
        end
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk_sys) begin
        if (!clr_n)         mstate = 0;
        else if (seed_en)   mstate = int'(seed_val);
        else if (mtick)     mstate = seq_next(mstate);
    end

    initial begin
        clr_n = 1'b1; btn_raw = 1'b0; seed_en = 1'b0; seed_val = 3'b000;
        #2 clr_n = 1'b0;
        repeat (3) @(posedge clk_sys);
        #1;
        chk(cnt_q == 3'b000, "R4 reset state q", int'(cnt_q), 0);
        chk(cnt_qn == 3'b111, "R4 reset state qn", int'(cnt_qn), 7);
        cmp_en = 1; clr_n = 1'b1;

        // several full wraps of the main loop (R1)
        repeat (5 * 5 * DIV + 3) @(posedge clk_sys);
        #1;
        chk(int'(cnt_q) == mstate, "R1 after wraps", int'(cnt_q), mstate);

        // seed unused codes and one main-loop code (R9, R3)
        foreach (seed_list[i]) begin
            @(posedge clk_sys); #1;
            seed_val = seed_list[i]; seed_en = 1'b1;
            @(posedge clk_sys); #1;
            seed_en = 1'b0;
            chk(int'(cnt_q) == int'(seed_list[i]), "R9 seed load", int'(cnt_q), int'(seed_list[i]));
            repeat (DIV) @(posedge clk_sys);
            #1;
            chk(int'(cnt_q) == seq_next(int'(seed_list[i])), "R3 recovery step",
                int'(cnt_q), seq_next(int'(seed_list[i])));
        end

        // clear in the same cycle as a due step, with a seed load also driven (R4, R9)
        do begin @(posedge clk_sys); #1; end while (!(mtick && mstate != 0));
        #1 clr_n = 1'b0; seed_en = 1'b1; seed_val = 3'b101;
        #1;
        chk(cnt_q == 3'b000, "R4 clear without edge q", int'(cnt_q), 0);
        chk(cnt_qn == 3'b111, "R4 clear without edge qn", int'(cnt_qn), 7);
        @(negedge clk_sys); #1;
        chk(cnt_q == 3'b000, "R4/R9 clear beats step and load", int'(cnt_q), 0);
        @(posedge clk_sys); #1;
        seed_en = 1'b0; clr_n = 1'b1;

        // mid-sequence clear away from a step
        do begin @(posedge clk_sys); #1; end while (!(mstate == 3 && !mtick));
        #1 clr_n = 1'b0;
        #1;
        chk(cnt_q == 3'b000, "R4 mid-sequence clear", int'(cnt_q), 0);
        @(posedge clk_sys); #1;
        clr_n = 1'b1;
        repeat (3 * DIV) @(posedge clk_sys);

        // short bounce is ignored (R8)
        btn_raw = 1'b1;
        repeat (DEB - 3) @(posedge clk_sys);
        #1 btn_raw = 1'b0;
        repeat (40) @(posedge clk_sys);
        #1;
        chk(int'(cnt_q) == mstate, "R8 short pulse ignored", int'(cnt_q), mstate);

        // long press clears (R7)
        do begin @(posedge clk_sys); #1; end while (mstate == 0);
        cmp_en = 0;
        btn_raw = 1'b1;
        repeat (DEB + 6) @(posedge clk_sys);
        #1;
        chk(cnt_q == 3'b000, "R7 held button clears q", int'(cnt_q), 0);
        chk(cnt_qn == 3'b111, "R7 held button clears qn", int'(cnt_qn), 7);
        repeat (3 * DIV) @(posedge clk_sys);
        #1;
        chk(cnt_q == 3'b000, "R7 stays clear while held", int'(cnt_q), 0);
        btn_raw = 1'b0;
        repeat (DEB + 6) @(posedge clk_sys);

        // resynchronise model and design, then run on
        #1 clr_n = 1'b0;
        @(posedge clk_sys); #1;
        clr_n = 1'b1; cmp_en = 1;
        repeat (60) @(posedge clk_sys);
        #1;
        chk(int'(cnt_q) == mstate, "R1 final state", int'(cnt_q), mstate);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [2:0] seed_list [4] = '{3'b100, 3'b110, 3'b111, 3'b101};

endmodule